// File: doc/BRIEF.md
# Serial ADC Conversion Master

This block is the host side of a link to an eight-channel, 16-bit serial sampling converter that runs from an externally supplied conversion clock. It takes a conversion request and builds the 8-bit command byte from it. It then drives chip select, the serial clock and the command data for a whole frame, shifts in the 16 result bits, and hands the word upward together with its channel number.

The converter returns its result one serial clock after the command byte ends. A full read therefore needs 25 serial clocks. Two frame shapes are offered. The long frame always runs 32 clocks and discards the tail. The overlapped frame runs 24 clocks per conversion: the start bit of the next command goes out on the same clock that brings back the previous least significant bit. A request can be queued one frame ahead. If none is queued when the next start bit falls due, one extra clock with a zero command bit collects the last result, and chip select is then raised.

All serial timing is counted in system clock cycles through parameters. `HALF_CYC` sets each serial clock half period and `CSS_CYC` sets the chip-select lead time. `ACQ_CYC` sets the minimum acquisition window, and the master holds the serial clock high on the eighth command clock until that window has passed.

Top module: `adc_serial_master`

## Requirements
- R1: The command byte is sent MSB first, one bit per serial clock, as 1, chan[2], chan[1], chan[0], 0, sgl, pd[1], pd[0]. `din_o` changes only on serial clock falling edges and is 1 when chip select falls.
- R2: Every serial clock low phase and high phase lasts exactly `HALF_CYC` system cycles, with two exceptions. The first low phase after chip select falls lasts `CSS_CYC + HALF_CYC` cycles. The high phase of the eighth clock follows R3.
- R3: From the rising edge of serial clock 5 to the falling edge of serial clock 8, exactly max(7*`HALF_CYC`, `ACQ_CYC`) system cycles pass.
- R4: Result bits 15 down to 0 are taken from `dout_i` at the rising edges of serial clocks 10 through 25. `res_valid_o` is a one-cycle pulse that rises in the same cycle as `dclk_o` rises for clock 25. It carries the 16-bit word and the channel of the command that produced it.
- R5: With `long_frame_i` = 1 at acceptance, a frame has exactly 32 serial clocks. Bits present on `dout_i` at clocks 26 to 32 have no effect on the result. `req_ready_o` stays 0 while chip select is low.
- R6: With `long_frame_i` = 0, a queued request continues the frame without raising chip select. Its start bit is sent on the clock that returns the previous LSB, so n chained conversions take 24*n+1 serial clocks under one chip select.
- R7: In overlapped mode with nothing queued, `din_o` is 0 on the 25th clock, and chip select then rises after that clock's falling edge.
- R8: In overlapped mode one further request is accepted during a frame, while the clock index is below 24 and no request is already queued. The frame mode is taken from `long_frame_i` only when a request is accepted from idle.
- R9: After reset `cs_no` = 1, `dclk_o` = 0, `din_o` = 0, `res_valid_o` = 0 and `req_ready_o` = 1.
- R10: `dclk_o` is never 1 while `cs_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| long_frame_i | input | 1 | 1 selects 32-clock frames, 0 selects overlapped 24-clock frames |
| req_valid_i | input | 1 | Conversion request present |
| req_ready_o | output | 1 | Request accepted when both valid and ready are 1 |
| req_chan_i | input | 3 | Channel address of the request |
| req_sgl_i | input | 1 | Input configuration bit placed in the command |
| req_pd_i | input | 2 | Power-down bits placed in the command |
| cs_no | output | 1 | Converter chip select, active low |
| dclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial command data to the converter |
| dout_i | input | 1 | Serial result data from the converter |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_data_o | output | 16 | Captured result word |
| res_chan_o | output | 3 | Channel the result belongs to |

## Verification
A behavioural converter in the bench reads the command bits at rising edges and returns a per-conversion word. Outside the data window it drives ones, so any misplaced sample or a read of the 32-clock tail shows up as a wrong word. Separate single requests in long mode separate the 32-clock shape and the blocked handshake from the overlapped path. A lone overlapped request isolates the extra zero-command clock. A burst of five chained requests checks the look-ahead acceptance, the 24*n+1 session length and the pairing of each word with the channel of the command that produced it. Every phase length and the stretched acquisition window are measured against the parameters on each serial clock edge.

// File: rtl/adc_master_pkg.sv
package adc_master_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned RES_W  = 16;
  localparam int unsigned CHAN_W = 3;
  localparam int unsigned IDX_W  = 6;

  // serial clock indices within a frame, counted from the start bit
  localparam logic [IDX_W-1:0] IDX_ONE    = 6'd1;
  localparam logic [IDX_W-1:0] IDX_ACQ_A  = 6'd5;
  localparam logic [IDX_W-1:0] IDX_ACQ_B  = 6'd8;
  localparam logic [IDX_W-1:0] IDX_CONV   = 6'd9;
  localparam logic [IDX_W-1:0] IDX_DATA0  = 6'd10;
  localparam logic [IDX_W-1:0] IDX_OVL    = 6'd24;
  localparam logic [IDX_W-1:0] IDX_LSB    = 6'd25;
  localparam logic [IDX_W-1:0] IDX_LONG   = 6'd32;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_e;

  function automatic logic [CMD_W-1:0] make_cmd(input logic [CHAN_W-1:0] ch,
                                                input logic sgl,
                                                input logic [1:0] pd);
    return {1'b1, ch, 1'b0, sgl, pd};
  endfunction
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // saturates at the limit so a stretched phase keeps done asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == limit_i);

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
endmodule

// File: rtl/adc_acq_guard.sv
module adc_acq_guard #(
  parameter int unsigned ACQ_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ok_o
);
  localparam int unsigned CW = (ACQ_CYC < 2) ? 1 : $clog2(ACQ_CYC + 1);
  localparam logic [CW-1:0] TOP = CW'(ACQ_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= '0;
    else if (cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == TOP);

  // once the window has elapsed it stays elapsed until re-armed
  assert_acq_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && !start_i) |=> ok_o);
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift import adc_master_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              last_i,
  input  logic              bit_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic              res_valid_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic [CHAN_W-1:0] res_chan_o
);
  logic [RES_W-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_chan_o  <= '0;
    end else begin
      res_valid_o <= shift_i && last_i;
      if (shift_i) sr_q <= {sr_q[RES_W-3:0], bit_i};
      if (shift_i && last_i) begin
        res_data_o <= {sr_q, bit_i};
        res_chan_o <= chan_i;
      end
    end
  end

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master import adc_master_pkg::*; #(
  parameter int unsigned HALF_CYC = 40,
  parameter int unsigned CSS_CYC  = 20,
  parameter int unsigned ACQ_CYC  = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              long_frame_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic              req_sgl_i,
  input  logic [1:0]        req_pd_i,
  output logic              cs_no,
  output logic              dclk_o,
  output logic              din_o,
  input  logic              dout_i,
  output logic              res_valid_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic [CHAN_W-1:0] res_chan_o
);
  localparam int unsigned TMAX = (HALF_CYC > CSS_CYC) ? HALF_CYC : CSS_CYC;
  localparam int unsigned TW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

  phase_e            ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CMD_W-1:0]  cmd_q, pend_cmd_q;
  logic [CHAN_W-1:0] chan_q, pend_chan_q, data_chan_q;
  logic              long_q, pend_q, owed_q, cs_q, dclk_q;

  logic              t_done, t_restart, acq_ok;
  logic [TW-1:0]     t_limit;
  logic              rise_ev, fall_ev, setup_end, accept_idle, accept_ahead;
  logic              chain, cap_en, cap_last;
  logic [IDX_W-1:0]  last_idx;

  assign t_limit      = (ph_q == PH_SETUP) ? TW'(CSS_CYC - 1) : TW'(HALF_CYC - 1);
  assign accept_idle  = (ph_q == PH_IDLE) && req_valid_i;
  assign req_ready_o  = (ph_q == PH_IDLE) || (!long_q && !pend_q && (idx_q < IDX_OVL));
  assign accept_ahead = (ph_q != PH_IDLE) && req_valid_i && req_ready_o;
  assign setup_end    = (ph_q == PH_SETUP) && t_done;
  assign rise_ev      = (ph_q == PH_LOW) && t_done;
  // clock 8 stays high until the acquisition window is long enough
  assign fall_ev      = (ph_q == PH_HIGH) && t_done && ((idx_q != IDX_ACQ_B) || acq_ok);
  assign t_restart    = accept_idle || setup_end || rise_ev || fall_ev;
  assign last_idx     = long_q ? IDX_LONG : IDX_LSB;
  assign chain        = !long_q && (idx_q == IDX_OVL) && pend_q;
  assign cap_last     = (idx_q == IDX_LSB) || ((idx_q == IDX_ONE) && owed_q);
  assign cap_en       = rise_ev && (((idx_q >= IDX_DATA0) && (idx_q <= IDX_LSB)) || cap_last);

  adc_phase_timer #(.CNT_W(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (t_restart),
    .limit_i   (t_limit),
    .done_o    (t_done)
  );

  adc_acq_guard #(.ACQ_CYC(ACQ_CYC)) u_acq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rise_ev && (idx_q == IDX_ACQ_A)),
    .ok_o    (acq_ok)
  );

  adc_rx_shift u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (cap_en),
    .last_i      (cap_last),
    .bit_i       (dout_i),
    .chan_i      (data_chan_q),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o),
    .res_chan_o  (res_chan_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      idx_q       <= '0;
      cmd_q       <= '0;
      pend_cmd_q  <= '0;
      chan_q      <= '0;
      pend_chan_q <= '0;
      data_chan_q <= '0;
      long_q      <= 1'b0;
      pend_q      <= 1'b0;
      owed_q      <= 1'b0;
      cs_q        <= 1'b1;
      dclk_q      <= 1'b0;
    end else begin
      if (accept_ahead) begin
        pend_q      <= 1'b1;
        pend_cmd_q  <= make_cmd(req_chan_i, req_sgl_i, req_pd_i);
        pend_chan_q <= req_chan_i;
      end
      unique case (ph_q)
        PH_IDLE: begin
          if (req_valid_i) begin
            ph_q   <= PH_SETUP;
            cs_q   <= 1'b0;
            idx_q  <= IDX_ONE;
            cmd_q  <= make_cmd(req_chan_i, req_sgl_i, req_pd_i);
            chan_q <= req_chan_i;
            long_q <= long_frame_i;
            owed_q <= 1'b0;
          end
        end
        PH_SETUP: begin
          if (t_done) ph_q <= PH_LOW;
        end
        PH_LOW: begin
          if (t_done) begin
            ph_q   <= PH_HIGH;
            dclk_q <= 1'b1;
            if (idx_q == IDX_CONV) data_chan_q <= chan_q;
            if (idx_q == IDX_ONE)  owed_q <= 1'b0;
          end
        end
        PH_HIGH: begin
          if (fall_ev) begin
            dclk_q <= 1'b0;
            if (chain) begin
              ph_q   <= PH_LOW;
              idx_q  <= IDX_ONE;
              cmd_q  <= pend_cmd_q;
              chan_q <= pend_chan_q;
              pend_q <= 1'b0;
              owed_q <= 1'b1;
            end else if (idx_q == last_idx) begin
              ph_q  <= PH_IDLE;
              cs_q  <= 1'b1;
              idx_q <= '0;
              cmd_q <= '0;
            end else begin
              ph_q  <= PH_LOW;
              idx_q <= idx_q + 1'b1;
              cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign cs_no  = cs_q;
  assign dclk_o = dclk_q;
  assign din_o  = cmd_q[CMD_W-1];

  assert_cs_idle_clk_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !dclk_o);
  assert_din_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_o && $past(dclk_o)) |-> $stable(din_o));
  assert_start_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> din_o);
  assert_acq_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dclk_o) && (idx_q == IDX_CONV)) |-> $past(acq_ok));
  assert_long_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && long_q) |-> !req_ready_o);
  assert_tail_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no) && !long_q) |-> !$past(din_o));
  assert_valid_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $rose(dclk_o));
endmodule

// File: tb/sim_adc_serial_master.sv
`timescale 1ns/1ps
module sim_adc_serial_master;
  localparam int HALF = 3;
  localparam int CSS  = 2;
  localparam int ACQ  = 30;
  localparam int ACQ_EXP = (7*HALF > ACQ) ? 7*HALF : ACQ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic long_sel = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic req_sgl = 1'b0;
  logic [1:0] req_pd = '0;
  logic req_ready, cs_n, dclk, din, res_valid;
  logic dout = 1'b0;
  logic [15:0] res_data;
  logic [2:0] res_chan;

  always #2.5 clk = ~clk;

  adc_serial_master #(.HALF_CYC(HALF), .CSS_CYC(CSS), .ACQ_CYC(ACQ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .long_frame_i(long_sel),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_chan_i(req_chan),
    .req_sgl_i(req_sgl), .req_pd_i(req_pd),
    .cs_no(cs_n), .dclk_o(dclk), .din_o(din), .dout_i(dout),
    .res_valid_o(res_valid), .res_data_o(res_data), .res_chan_o(res_chan));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0]  exp_cmd[$];
  logic [18:0] exp_res[$];
  int ahead_accepts = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model and per-clock comparisons
  int cyc = 0, last_t = 0, r5_t = 0, sess_rises = 0, dev_pos = 0, seq = 0;
  bit prev_dclk = 0, prev_cs = 1, prev_valid = 0, first_low = 0, last_din = 0;
  logic [7:0] dev_cmd = '0;
  logic [15:0] cur_data = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_dclk = 0; prev_cs = 1; prev_valid = 0; dev_pos = 0;
    end else begin
      bit rise, fall;
      cyc++;
      rise = !prev_dclk && dclk;
      fall = prev_dclk && !dclk;
      chk(!(cs_n && dclk), "R10 clock while deselected", dclk, 0);
      if (prev_cs && !cs_n) begin
        last_t = cyc; first_low = 1; sess_rises = 0;
      end
      if (rise) begin
        int lo, el;
        lo = cyc - last_t;
        el = first_low ? CSS + HALF : HALF;
        chk(lo == el, "R2 low phase", lo, el);
        first_low = 0; last_t = cyc;
        sess_rises++; last_din = din;
        if ((dev_pos == 0 || dev_pos >= 24) && din) begin
          dev_pos = 1; dev_cmd = 8'h01;
        end else if (dev_pos != 0) begin
          dev_pos++;
          if (dev_pos <= 8) dev_cmd = {dev_cmd[6:0], din};
        end
        if (dev_pos == 5) r5_t = cyc;
        if (dev_pos == 8) begin
          logic [7:0] ec;
          ec = (exp_cmd.size() > 0) ? exp_cmd.pop_front() : 8'h00;
          chk(dev_cmd == ec, "R1 command byte", dev_cmd, ec);
          cur_data = 16'hA5C3 ^ (16'(seq) * 16'h1F1D) ^ {dev_cmd[6:4], 13'h0};
          seq++;
          exp_res.push_back({dev_cmd[6:4], cur_data});
        end
      end
      if (fall) begin
        int hi;
        hi = cyc - last_t;
        if (dev_pos == 8) chk(cyc - r5_t == ACQ_EXP, "R3 acquisition window", cyc - r5_t, ACQ_EXP);
        else              chk(hi == HALF, "R2 high phase", hi, HALF);
        last_t = cyc;
        // ones outside the data window expose any stray sample
        dout = (dev_pos >= 9 && dev_pos <= 24) ? cur_data[24 - dev_pos] : 1'b1;
      end
      if (!prev_cs && cs_n) begin
        if (long_sel) chk(sess_rises == 32, "R5 long frame clocks", sess_rises, 32);
        else begin
          chk(sess_rises >= 25 && (sess_rises - 1) % 24 == 0, "R6 overlapped session clocks",
              sess_rises, 25);
          chk(last_din == 0, "R7 final command bit", last_din, 0);
        end
        dev_pos = 0; dout = 1'b0;
      end
      if (long_sel && !cs_n) chk(!req_ready, "R5 ready during long frame", req_ready, 0);
      if (res_valid) begin
        logic [18:0] er;
        chk(!prev_valid, "R4 valid pulse width", prev_valid, 0);
        chk(rise, "R4 valid with clock 25 rise", rise, 1);
        er = (exp_res.size() > 0) ? exp_res.pop_front() : 19'h0;
        chk(res_data == er[15:0], "R4 result data", res_data, er[15:0]);
        chk(res_chan == er[18:16], "R4 result channel", res_chan, er[18:16]);
      end
      prev_valid = res_valid; prev_dclk = dclk; prev_cs = cs_n;
    end
  end

  task automatic send(input logic [2:0] ch, input logic sgl, input logic [1:0] pd);
    req_valid = 1'b1; req_chan = ch; req_sgl = sgl; req_pd = pd;
    while (!req_ready) @(negedge clk);
    if (!cs_n) ahead_accepts++;
    exp_cmd.push_back({1'b1, ch, 1'b0, sgl, pd});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(cs_n && exp_res.size() == 0 && exp_cmd.size() == 0));
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cs_n == 1'b1, "R9 cs after reset", cs_n, 1);
    chk(dclk == 1'b0, "R9 dclk after reset", dclk, 0);
    chk(din == 1'b0, "R9 din after reset", din, 0);
    chk(res_valid == 1'b0, "R9 valid after reset", res_valid, 0);
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

    // long frames, second request blocked until idle (R5)
    long_sel = 1'b1;
    send(3'd3, 1'b1, 2'b00);
    send(3'd5, 1'b0, 2'b11);
    send(3'd0, 1'b1, 2'b10);
    wait_idle();

    // single overlapped conversion ends with an extra zero clock (R7)
    long_sel = 1'b0;
    send(3'd7, 1'b1, 2'b01);
    wait_idle();

    // chained overlapped burst uses look-ahead acceptance (R6, R8)
    ahead_accepts = 0;
    for (int i = 0; i < 5; i++) send(3'((i * 3 + 2) % 8), 1'(i % 2), 2'(i));
    wait_idle();
    chk(ahead_accepts == 4, "R8 look-ahead accepts", ahead_accepts, 4);

    // mode switch back to long after overlapped traffic
    long_sel = 1'b1;
    send(3'd6, 1'b0, 2'b01);
    wait_idle();

    chk(exp_res.size() == 0, "R4 all results delivered", exp_res.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule